// File: doc/BRIEF.md
# USB Bus State Event Detector

This block watches the decoded line state of a full-speed USB device port. The line state is J, K, SE0 or SE1, and the block samples it on a clock whose frequency is a parameter. It measures how long each line condition lasts. From those durations it raises four status flags: bus reset, suspend, resume and response time-out. When any of those flags rises, the block sends a one-cycle bus-event pulse to the interrupt logic. It also sends a one-cycle wake pulse when the bus leaves a suspended state.

The block also handles the two forced-drive controls of the port. One control drives a K state for remote wake-up. The other drives SE0. A separate attach input passes through a synchronizer and comes out as the floating-detect bit, with a one-cycle event pulse on every change. Every threshold is derived from `CLK_HZ`. The reset threshold is `CLK_HZ/400000` cycles (2.5 us). The suspend threshold is `3*CLK_HZ/1000` cycles (3 ms). The response time-out is 18 bit times, where one bit time is `CLK_HZ/12000000` cycles.

Top module: `usb_bus_watch`

## Requirements
- R1: The line encoding on `line_i` is 00 = SE0, 01 = J (idle), 10 = K, 11 = SE1. `status_o[0]` (bus reset) is 1 exactly when the last RESET_CYC+1 or more consecutive samples were SE0. It clears on the first sample that is not SE0.
- R2: `status_o[1]` (suspend) is 1 exactly when the last SUSP_CYC+1 or more consecutive samples were J. It clears on the first sample that is not J.
- R3: A non-J sample taken while suspend is set raises `status_o[2]` (resume) and gives a single-cycle `wake_o` pulse in the same cycle. Resume stays set until a J sample arrives.
- R4: A `tx_done_i` sample arms a response window. If TO_CYC+1 further samples are J, `status_o[3]` (time-out) is set. A non-J sample before that point disarms the window and no time-out is raised. Time-out clears on a non-J sample or on a new `tx_done_i`.
- R5: The status bit order is fixed: bit 0 reset, bit 1 suspend, bit 2 resume, bit 3 time-out. After reset, all four bits are 0.
- R6: `bus_evt_o` is high for exactly the one cycle in which any status bit goes from 0 to 1.
- R7: When `rwake_i` is 1 and `force_se0_i` is 0, the outputs are `drv_en_o`=1, `dp_o`=0, `dm_o`=1 (K). When both controls are 0, all three outputs are 0.
- R8: `force_se0_i`=1 drives `drv_en_o`=1, `dp_o`=0, `dm_o`=0, and it takes priority over `rwake_i`.
- R9: `fldet_o` follows `attach_i` after SYNC_STAGES clock edges. `attach_evt_o` is high for the one cycle in which `fldet_o` takes a new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling clock of CLK_HZ |
| rst_ni | input | 1 | Active-low asynchronous reset |
| line_i | input | 2 | Decoded line state (00 SE0, 01 J, 10 K, 11 SE1) |
| tx_done_i | input | 1 | Device finished transmitting; arms response window |
| attach_i | input | 1 | Asynchronous attach indication |
| rwake_i | input | 1 | Remote wake-up request, drives K |
| force_se0_i | input | 1 | Force SE0 on the bus |
| status_o | output | 4 | {time-out, resume, suspend, reset} |
| bus_evt_o | output | 1 | Pulse on any status bit rising |
| wake_o | output | 1 | Pulse on leaving suspend |
| fldet_o | output | 1 | Synchronized attach state |
| attach_evt_o | output | 1 | Pulse on attach/detach |
| drv_en_o | output | 1 | Transceiver forced-drive enable |
| dp_o | output | 1 | Forced D+ level |
| dm_o | output | 1 | Forced D- level |

## Verification
The bench runs with a 12 MHz parameter so that every threshold is small: reset after 30 cycles, time-out after 18, suspend after 36000. SE0 runs of every length from 1 to 40 samples are applied, so the reset flag must switch exactly at the threshold and the event pulse must appear only on the crossing sample. Response delays of 1 to 22 samples are applied to check the time-out boundary, and an early response checks that the window is disarmed. A full suspend hold followed by a K checks that the suspend flag hands over to resume and that the wake pulse comes exactly once. All four combinations of the drive controls are tried, which tells the K priority apart from the SE0 priority.

// File: rtl/usb_bus_pkg.sv
`timescale 1ns/1ps
package usb_bus_pkg;
  typedef enum logic [1:0] {
    LS_SE0 = 2'b00,
    LS_J   = 2'b01,
    LS_K   = 2'b10,
    LS_SE1 = 2'b11
  } line_e;

  localparam int ST_RESET  = 0;
  localparam int ST_SUSP   = 1;
  localparam int ST_RESUME = 2;
  localparam int ST_TMO    = 3;
  localparam int ST_W      = 4;
endpackage

// File: rtl/usb_line_timer.sv
`timescale 1ns/1ps
module usb_line_timer
  import usb_bus_pkg::*;
#(
  parameter int unsigned RESET_CYC = 120,
  parameter int unsigned SUSP_CYC  = 144000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] line_i,
  output logic       reset_o,
  output logic       suspend_o,
  output logic       resume_o,
  output logic       wake_o
);
  localparam int unsigned CW = $clog2(SUSP_CYC + 1);
  localparam logic [CW-1:0] SAT = CW'(SUSP_CYC);
  localparam logic [CW-1:0] RST_TH = CW'(RESET_CYC);

  line_e         line_q;
  logic [CW-1:0] run_q;
  logic          resume_q, wake_q;

  // run_q counts repeat samples of the current state, saturating
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      line_q <= LS_J;
      run_q  <= '0;
    end else begin
      line_q <= line_e'(line_i);
      if (line_i != line_q) run_q <= '0;
      else if (run_q != SAT) run_q <= run_q + 1'b1;
    end
  end

  assign reset_o   = (line_q == LS_SE0) && (run_q >= RST_TH);
  assign suspend_o = (line_q == LS_J) && (run_q == SAT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      resume_q <= 1'b0;
      wake_q   <= 1'b0;
    end else begin
      wake_q <= suspend_o && (line_i != LS_J);
      if (suspend_o && (line_i != LS_J)) resume_q <= 1'b1;
      else if (line_i == LS_J)           resume_q <= 1'b0;
    end
  end

  assign resume_o = resume_q;
  assign wake_o   = wake_q;
endmodule

// File: rtl/usb_resp_timer.sv
`timescale 1ns/1ps
module usb_resp_timer
  import usb_bus_pkg::*;
#(
  parameter int unsigned TO_CYC = 72
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] line_i,
  input  logic       tx_done_i,
  output logic       timeout_o
);
  localparam int unsigned CW = $clog2(TO_CYC + 1);
  localparam logic [CW-1:0] LIM = CW'(TO_CYC);

  logic          armed_q, tmo_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      tmo_q   <= 1'b0;
      cnt_q   <= '0;
    end else if (tx_done_i) begin
      armed_q <= 1'b1;
      tmo_q   <= 1'b0;
      cnt_q   <= '0;
    end else if (line_i != LS_J) begin
      armed_q <= 1'b0;   // response seen
      tmo_q   <= 1'b0;
    end else if (armed_q) begin
      if (cnt_q == LIM) begin
        tmo_q   <= 1'b1;
        armed_q <= 1'b0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign timeout_o = tmo_q;
endmodule

// File: rtl/usb_attach_sync.sv
`timescale 1ns/1ps
module usb_attach_sync #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic attach_i,
  output logic fldet_o,
  output logic attach_evt_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   seen_q;

  for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q[0] <= 1'b0;
        else         sync_q[0] <= attach_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q[s] <= 1'b0;
        else         sync_q[s] <= sync_q[s-1];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) seen_q <= 1'b0;
    else         seen_q <= sync_q[SYNC_STAGES-1];
  end

  assign fldet_o      = sync_q[SYNC_STAGES-1];
  assign attach_evt_o = sync_q[SYNC_STAGES-1] ^ seen_q;
endmodule

// File: rtl/usb_bus_watch.sv
`timescale 1ns/1ps
module usb_bus_watch
  import usb_bus_pkg::*;
#(
  parameter int unsigned CLK_HZ      = 48_000_000,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [1:0]      line_i,
  input  logic            tx_done_i,
  input  logic            attach_i,
  input  logic            rwake_i,
  input  logic            force_se0_i,
  output logic [ST_W-1:0] status_o,
  output logic            bus_evt_o,
  output logic            wake_o,
  output logic            fldet_o,
  output logic            attach_evt_o,
  output logic            drv_en_o,
  output logic            dp_o,
  output logic            dm_o
);
  localparam int unsigned BIT_CYC   = CLK_HZ / 12_000_000;
  localparam int unsigned RESET_CYC = CLK_HZ / 400_000;
  localparam int unsigned SUSP_CYC  = (CLK_HZ / 1000) * 3;
  localparam int unsigned TO_CYC    = 18 * BIT_CYC;

  logic [ST_W-1:0] flags, flags_q;

  usb_line_timer #(.RESET_CYC(RESET_CYC), .SUSP_CYC(SUSP_CYC)) u_line (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .line_i    (line_i),
    .reset_o   (flags[ST_RESET]),
    .suspend_o (flags[ST_SUSP]),
    .resume_o  (flags[ST_RESUME]),
    .wake_o    (wake_o)
  );

  usb_resp_timer #(.TO_CYC(TO_CYC)) u_resp (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .line_i    (line_i),
    .tx_done_i (tx_done_i),
    .timeout_o (flags[ST_TMO])
  );

  usb_attach_sync #(.SYNC_STAGES(SYNC_STAGES)) u_att (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .attach_i     (attach_i),
    .fldet_o      (fldet_o),
    .attach_evt_o (attach_evt_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flags_q <= '0;
    else         flags_q <= flags;
  end

  assign status_o  = flags;
  assign bus_evt_o = |(flags & ~flags_q);

  // SE0 wins over remote-wake K
  always_comb begin
    drv_en_o = force_se0_i | rwake_i;
    dp_o     = 1'b0;
    dm_o     = rwake_i & ~force_se0_i;
  end
endmodule

// File: rtl/usb_bus_watch_chk.sv
`timescale 1ns/1ps
module usb_bus_watch_chk
  import usb_bus_pkg::*;
(
  input logic            clk_i,
  input logic            rst_ni,
  input logic [1:0]      line_i,
  input logic            tx_done_i,
  input logic            attach_i,
  input logic            rwake_i,
  input logic            force_se0_i,
  input logic [ST_W-1:0] status_o,
  input logic            bus_evt_o,
  input logic            wake_o,
  input logic            fldet_o,
  input logic            attach_evt_o,
  input logic            drv_en_o,
  input logic            dp_o,
  input logic            dm_o
);
  AST_RESET_ON_SE0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[ST_RESET] |-> $past(line_i) == 2'b00); // R1
  AST_SUSP_ON_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[ST_SUSP] |-> $past(line_i) == 2'b01); // R2
  AST_WAKE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |=> !wake_o); // R3
  AST_WAKE_RESUME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |-> status_o[ST_RESUME]); // R3
  AST_TMO_ON_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[ST_TMO] |-> $past(line_i) == 2'b01); // R4
  AST_EVT_HAS_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_evt_o |-> (|status_o)); // R6
  AST_FORCE_K: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rwake_i && !force_se0_i) |-> (drv_en_o && !dp_o && dm_o)); // R7
  AST_FORCE_SE0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    force_se0_i |-> (drv_en_o && !dp_o && !dm_o)); // R8
  AST_ATTACH_EVT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    attach_evt_o |=> !attach_evt_o || $changed(fldet_o)); // R9
endmodule

bind usb_bus_watch usb_bus_watch_chk u_chk (.*);

// File: tb/usb_bus_watch_test.sv
`timescale 1ns/1ps
module usb_bus_watch_test;
  localparam int unsigned HZ     = 12_000_000;
  localparam int          RST_TH = 30;     // HZ/400000
  localparam int          SUS_TH = 36000;  // 3*HZ/1000
  localparam int          TO_TH  = 18;     // 18 bit times, 1 cycle each

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] line = 2'b01;
  logic       tx_done = 1'b0, attach = 1'b0, rwake = 1'b0, fse0 = 1'b0;
  logic [3:0] status;
  logic       bus_evt, wake, fldet, att_evt, drv_en, dp, dm;
  int         checks = 0, fails = 0;
  bit         done = 1'b0;

  always #2 clk = ~clk;

  usb_bus_watch #(.CLK_HZ(HZ), .SYNC_STAGES(2)) uut (
    .clk_i(clk), .rst_ni(rst_n), .line_i(line), .tx_done_i(tx_done),
    .attach_i(attach), .rwake_i(rwake), .force_se0_i(fse0),
    .status_o(status), .bus_evt_o(bus_evt), .wake_o(wake), .fldet_o(fldet),
    .attach_evt_o(att_evt), .drv_en_o(drv_en), .dp_o(dp), .dm_o(dm)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(4 * 200000);
    fails++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    chk("R5 reset state status", 32'(status), 0);
    chk("R5 reset state events", 32'({bus_evt, wake, fldet, att_evt}), 0);
    chk("R7 reset state drive", 32'({drv_en, dp, dm}), 0);

    // R1: SE0 length sweep
    for (int n = 1; n <= 40; n++) begin
      line = 2'b01; step(3);
      line = 2'b00; step(n);
      chk("R1 reset at SE0 length", 32'(status[0]), 32'(n >= RST_TH + 1));
      chk("R5 only reset bit", 32'(status[3:1]), 0);
      if (n == RST_TH + 1) chk("R6 event on reset rise", 32'(bus_evt), 1);
      if (n == RST_TH + 2) chk("R6 event single cycle", 32'(bus_evt), 0);
      chk("R3 no wake outside suspend", 32'(wake), 0);
      line = 2'b01; step(1);
      chk("R1 reset clears on J", 32'(status[0]), 0);
    end

    // R4: response delay sweep
    for (int m = 1; m <= 22; m++) begin
      tx_done = 1'b1; step(1); tx_done = 1'b0;
      step(m);
      chk("R4 timeout at delay", 32'(status[3]), 32'(m >= TO_TH + 1));
      if (m == TO_TH + 1) chk("R6 event on timeout rise", 32'(bus_evt), 1);
      line = 2'b10; step(1);
      chk("R4 timeout clears on K", 32'(status[3]), 0);
      line = 2'b01; step(1);
    end
    tx_done = 1'b1; step(1); tx_done = 1'b0;
    step(5);
    line = 2'b10; step(1);
    line = 2'b01; step(30);
    chk("R4 early response disarms", 32'(status[3]), 0);

    // R2/R3: suspend then resume
    line = 2'b10; step(2);
    line = 2'b01; step(SUS_TH);
    chk("R2 no suspend at threshold", 32'(status[1]), 0);
    step(1);
    chk("R2 suspend after threshold", 32'(status), 32'h2);
    chk("R6 event on suspend rise", 32'(bus_evt), 1);
    line = 2'b10; step(1);
    chk("R3 resume replaces suspend", 32'(status), 32'h4);
    chk("R3 wake pulse", 32'(wake), 1);
    chk("R6 event on resume rise", 32'(bus_evt), 1);
    step(1);
    chk("R3 wake one cycle", 32'(wake), 0);
    chk("R3 resume held during K", 32'(status), 32'h4);
    line = 2'b01; step(1);
    chk("R3 resume clears on J", 32'(status), 0);

    // R7/R8: drive controls
    for (int v = 0; v < 4; v++) begin
      fse0 = v[1]; rwake = v[0]; #1;
      if (v[1])      chk("R8 forced SE0", 32'({drv_en, dp, dm}), 32'b100);
      else if (v[0]) chk("R7 forced K", 32'({drv_en, dp, dm}), 32'b101);
      else           chk("R7 released", 32'({drv_en, dp, dm}), 32'b000);
    end
    fse0 = 1'b0; rwake = 1'b0;
    step(1);

    // R9: attach sync
    attach = 1'b1; step(1);
    chk("R9 fldet after one edge", 32'(fldet), 0);
    step(1);
    chk("R9 fldet after sync", 32'(fldet), 1);
    chk("R9 attach event", 32'(att_evt), 1);
    step(1);
    chk("R9 attach event single", 32'(att_evt), 0);
    attach = 1'b0; step(2);
    chk("R9 detach", 32'({fldet, att_evt}), 32'b01);

    finish_up();
  end
endmodule